// File: doc/BRIEF.md
# PCI Legacy Interrupt Swizzle and Router

This block turns legacy PCI interrupt requests into levels on interrupt-controller inputs. A requesting device presents an event carrying its device/function number, its interrupt pin index (0 for INTA up to 3 for INTD) and the new level of that pin. The block derives the slot from the device/function number and picks one of four shared PCI interrupt lines. Two on-board slots map to fixed lines. A window of four expansion slots rotates the pin by the slot position. Every other slot passes the pin index straight through. The level of each PCI line is held in a register.

A small routing table holds one entry per PCI line, written over a plain register port. Each entry names one of sixteen controller inputs, or switches the line off with its top bit. Each controller input is the OR of the levels of every enabled PCI line whose entry points at it. The outputs are recomputed from the whole table and all line levels, so a rewritten entry takes effect at once.

Events arrive on a valid/ready interface. The producer must hold an event stable while `evt_valid` is high and `evt_ready` is low. The block withholds `evt_ready` only in a cycle that also carries a table write.

Top module: `intx_router`

## Requirements
- R1: The slot number is `evt_devfn[7:3]`. The function bits `evt_devfn[2:0]` do not affect the chosen line.
- R2: For slots 18 to 21, the chosen line is `(slot - 18 + pin) mod 4`. For example, slot 21 with pin 3 selects line 2.
- R3: Slot 10 always selects line 2 and slot 11 always selects line 3, whatever the pin index.
- R4: A device in any other slot, including 17 and 22, selects the line equal to its pin index.
- R5: An event is accepted on a clock edge where `evt_valid` and `evt_ready` are both high. The chosen line then holds `evt_level` from that edge onward.
- R6: After each edge, `ctrl_irq[k]` is the OR of the levels of all enabled lines whose entry has `entry[3:0] == k`. It is 0 when no such line is high. It changes only after an accepted event or a table write.
- R7: An entry with bit 7 set disables its line. That line then drives no controller input, whatever its level.
- R8: Writing an entry recomputes every controller input from the same edge. A line moved to a new target leaves no level on its old target.
- R9: Reset clears all line levels to 0, sets every entry to 0x80 and drives `ctrl_irq` to 0.
- R10: `evt_ready` is low exactly in cycles where `cfg_we` is high. The table write wins, and the stalled event is accepted on a later edge.
- R11: A write stores all 8 bits of `cfg_wdata` into entry `cfg_idx`. `cfg_rdata` always shows entry `cfg_ridx` as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | An interrupt pin change is offered |
| evt_ready | output | 1 | The offered change is taken this cycle |
| evt_devfn | input | 8 | Device/function number of the requester |
| evt_pin | input | 2 | Interrupt pin index, 0 for INTA to 3 for INTD |
| evt_level | input | 1 | New level of that pin |
| cfg_we | input | 1 | Write a routing entry |
| cfg_idx | input | 2 | Entry written |
| cfg_wdata | input | 8 | Entry value: bit 7 disables, bits 3:0 pick the controller input |
| cfg_ridx | input | 2 | Entry shown on `cfg_rdata` |
| cfg_rdata | output | 8 | Stored value of entry `cfg_ridx` |
| ctrl_irq | output | 16 | Level of each interrupt-controller input |

## Verification
The assertions assume the producer obeys the back-pressure rule: an event offered while `evt_ready` is low stays valid into the next cycle. They also assume the outputs move only in response to an accepted event or a table write. The stimulus honours the rule by construction. After any cycle in which it offered an event alongside a table write, it keeps that same event on the port for the following cycle. Otherwise it draws slots across the whole range, including the fixed slots, both ends of the rotation window and the slots just outside it, and it mixes disabled, colliding and moved routing entries.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int unsigned DEF_LINES      = 4;
  localparam int unsigned DEF_INPUTS     = 16;
  localparam int unsigned DEF_ENTRY_W    = 8;
  localparam int unsigned DEF_DEVFN_W    = 8;
  localparam int unsigned DEF_ROT_FIRST  = 18;
  localparam int unsigned DEF_FIX_SLOT_A = 10;
  localparam int unsigned DEF_FIX_LINE_A = 2;
  localparam int unsigned DEF_FIX_SLOT_B = 11;
  localparam int unsigned DEF_FIX_LINE_B = 3;

  // How a slot was classified by the swizzle stage
  typedef enum logic [1:0] {
    SLOT_PASS  = 2'd0,
    SLOT_FIXED = 2'd1,
    SLOT_ROT   = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/intx_swizzle.sv
module intx_swizzle
  import intx_pkg::*;
#(
  parameter int unsigned LINES      = DEF_LINES,
  parameter int unsigned DEVFN_W    = DEF_DEVFN_W,
  parameter int unsigned ROT_FIRST  = DEF_ROT_FIRST,
  parameter int unsigned FIX_SLOT_A = DEF_FIX_SLOT_A,
  parameter int unsigned FIX_LINE_A = DEF_FIX_LINE_A,
  parameter int unsigned FIX_SLOT_B = DEF_FIX_SLOT_B,
  parameter int unsigned FIX_LINE_B = DEF_FIX_LINE_B,
  localparam int unsigned LINE_W    = $clog2(LINES),
  localparam int unsigned SLOT_W    = DEVFN_W - 3
) (
  input  logic [DEVFN_W-1:0] devfn,
  input  logic [LINE_W-1:0]  pin,
  output logic [LINE_W-1:0]  line,
  output slot_kind_e         kind
);
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] offset;
  logic [2:0]        func_unused;

  assign slot        = devfn[DEVFN_W-1:3];
  assign func_unused = devfn[2:0];
  assign offset      = slot - SLOT_W'(ROT_FIRST);

  always_comb begin
    kind = SLOT_PASS;
    line = pin;
    if (slot == SLOT_W'(FIX_SLOT_A)) begin
      kind = SLOT_FIXED;
      line = LINE_W'(FIX_LINE_A);
    end else if (slot == SLOT_W'(FIX_SLOT_B)) begin
      kind = SLOT_FIXED;
      line = LINE_W'(FIX_LINE_B);
    end else if (slot >= SLOT_W'(ROT_FIRST) && offset < SLOT_W'(LINES)) begin
      kind = SLOT_ROT;
      line = offset[LINE_W-1:0] + pin;
    end
  end
endmodule

// File: rtl/intx_line_state.sv
module intx_line_state #(
  parameter int unsigned LINES  = 4,
  localparam int unsigned LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [LINE_W-1:0] sel,
  input  logic              level,
  output logic [LINES-1:0]  lines_q
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lines_q[l] <= 1'b0;
      else if (upd && sel == LINE_W'(l))
        lines_q[l] <= level;
    end
  end
endmodule

// File: rtl/intx_route_table.sv
module intx_route_table #(
  parameter int unsigned LINES   = 4,
  parameter int unsigned ENTRY_W = 8,
  localparam int unsigned LINE_W = $clog2(LINES),
  localparam logic [ENTRY_W-1:0] OFF_VALUE = {1'b1, {(ENTRY_W-1){1'b0}}}
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [LINE_W-1:0]               idx,
  input  logic [ENTRY_W-1:0]              wdata,
  input  logic [LINE_W-1:0]               ridx,
  output logic [ENTRY_W-1:0]              rdata,
  output logic [LINES-1:0][ENTRY_W-1:0]   tab_q
);
  for (genvar l = 0; l < LINES; l++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tab_q[l] <= OFF_VALUE;
      else if (we && idx == LINE_W'(l))
        tab_q[l] <= wdata;
    end
  end

  assign rdata = tab_q[ridx];
endmodule

// File: rtl/intx_or_matrix.sv
module intx_or_matrix #(
  parameter int unsigned LINES   = 4,
  parameter int unsigned INPUTS  = 16,
  parameter int unsigned ENTRY_W = 8,
  localparam int unsigned TGT_W  = $clog2(INPUTS)
) (
  input  logic [LINES-1:0]                lines,
  input  logic [LINES-1:0][ENTRY_W-1:0]   tab,
  output logic [INPUTS-1:0]               irq
);
  logic [LINES-1:0] live;
  logic [INPUTS-1:0][LINES-1:0] hit;
  logic [LINES-1:0][ENTRY_W-2-TGT_W:0] spare_unused;

  for (genvar l = 0; l < LINES; l++) begin : g_live
    assign live[l]         = lines[l] & ~tab[l][ENTRY_W-1];
    assign spare_unused[l] = tab[l][ENTRY_W-2:TGT_W];
  end

  for (genvar k = 0; k < INPUTS; k++) begin : g_input
    for (genvar l = 0; l < LINES; l++) begin : g_src
      assign hit[k][l] = live[l] & (tab[l][TGT_W-1:0] == TGT_W'(k));
    end
    assign irq[k] = |hit[k];
  end
endmodule

// File: rtl/intx_router.sv
module intx_router
  import intx_pkg::*;
#(
  parameter int unsigned LINES      = DEF_LINES,
  parameter int unsigned INPUTS     = DEF_INPUTS,
  parameter int unsigned ENTRY_W    = DEF_ENTRY_W,
  parameter int unsigned DEVFN_W    = DEF_DEVFN_W,
  parameter int unsigned ROT_FIRST  = DEF_ROT_FIRST,
  parameter int unsigned FIX_SLOT_A = DEF_FIX_SLOT_A,
  parameter int unsigned FIX_LINE_A = DEF_FIX_LINE_A,
  parameter int unsigned FIX_SLOT_B = DEF_FIX_SLOT_B,
  parameter int unsigned FIX_LINE_B = DEF_FIX_LINE_B,
  localparam int unsigned LINE_W    = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               evt_valid,
  output logic               evt_ready,
  input  logic [DEVFN_W-1:0] evt_devfn,
  input  logic [LINE_W-1:0]  evt_pin,
  input  logic               evt_level,
  input  logic               cfg_we,
  input  logic [LINE_W-1:0]  cfg_idx,
  input  logic [ENTRY_W-1:0] cfg_wdata,
  input  logic [LINE_W-1:0]  cfg_ridx,
  output logic [ENTRY_W-1:0] cfg_rdata,
  output logic [INPUTS-1:0]  ctrl_irq
);
  logic [LINE_W-1:0]              line_sel;
  slot_kind_e                     kind_unused;
  logic                           take;
  logic [LINES-1:0]               line_level;
  logic [LINES-1:0][ENTRY_W-1:0]  cfg_tab;

  // A table write owns the cycle; the event waits
  assign evt_ready = ~cfg_we;
  assign take      = evt_valid & evt_ready;

  intx_swizzle #(
    .LINES(LINES), .DEVFN_W(DEVFN_W), .ROT_FIRST(ROT_FIRST),
    .FIX_SLOT_A(FIX_SLOT_A), .FIX_LINE_A(FIX_LINE_A),
    .FIX_SLOT_B(FIX_SLOT_B), .FIX_LINE_B(FIX_LINE_B)
  ) u_swz (
    .devfn(evt_devfn), .pin(evt_pin), .line(line_sel), .kind(kind_unused)
  );

  intx_line_state #(.LINES(LINES)) u_lines (
    .clk(clk), .rst_n(rst_n), .upd(take), .sel(line_sel),
    .level(evt_level), .lines_q(line_level)
  );

  intx_route_table #(.LINES(LINES), .ENTRY_W(ENTRY_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .wdata(cfg_wdata),
    .ridx(cfg_ridx), .rdata(cfg_rdata), .tab_q(cfg_tab)
  );

  intx_or_matrix #(.LINES(LINES), .INPUTS(INPUTS), .ENTRY_W(ENTRY_W)) u_or (
    .lines(line_level), .tab(cfg_tab), .irq(ctrl_irq)
  );
endmodule

// File: rtl/intx_router_sva.sv
module intx_router_sva #(
  parameter int unsigned LINES   = 4,
  parameter int unsigned INPUTS  = 16,
  parameter int unsigned ENTRY_W = 8,
  localparam int unsigned LINE_W = $clog2(LINES)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           evt_valid,
  input logic                           evt_ready,
  input logic                           evt_level,
  input logic                           cfg_we,
  input logic [LINE_W-1:0]              cfg_idx,
  input logic [ENTRY_W-1:0]             cfg_wdata,
  input logic [INPUTS-1:0]              ctrl_irq,
  input logic [LINE_W-1:0]              line_sel,
  input logic [LINES-1:0]               line_level,
  input logic [LINES-1:0][ENTRY_W-1:0]  cfg_tab
);
  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int l = 0; l < LINES; l++) all_off &= cfg_tab[l][ENTRY_W-1];
  end

  p_write_yields_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !evt_ready);

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> evt_valid);

  p_level_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_ready) |=> line_level[$past(line_sel)] == $past(evt_level));

  p_entry_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_tab[$past(cfg_idx)] == $past(cfg_wdata));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(evt_valid && evt_ready) && !cfg_we) |=> $stable(ctrl_irq));

  p_no_lines_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_level == '0) |-> (ctrl_irq == '0));

  p_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |-> (ctrl_irq == '0));
endmodule

bind intx_router intx_router_sva #(
  .LINES(LINES), .INPUTS(INPUTS), .ENTRY_W(ENTRY_W)
) u_sva (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
  .evt_level(evt_level), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
  .cfg_wdata(cfg_wdata), .ctrl_irq(ctrl_irq), .line_sel(line_sel),
  .line_level(line_level), .cfg_tab(cfg_tab)
);

// File: tb/intx_router_tb.sv
`timescale 1ns/1ps
module intx_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [7:0]  evt_devfn = '0;
  logic [1:0]  evt_pin = '0;
  logic        evt_level = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [1:0]  cfg_ridx = '0;
  logic [7:0]  cfg_rdata;
  logic [15:0] ctrl_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int ref_lev [4];
  int ref_tab [4];

  always #5 clk = ~clk;

  intx_router u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_devfn(evt_devfn), .evt_pin(evt_pin), .evt_level(evt_level),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata), .ctrl_irq(ctrl_irq)
  );

  function automatic int ref_line(int devfn, int pin);
    int slot = devfn / 8;
    if (slot == 10) return 2;
    if (slot == 11) return 3;
    if (slot >= 18 && slot <= 21) return (slot - 18 + pin) % 4;
    return pin;
  endfunction

  function automatic logic [15:0] ref_out();
    logic [15:0] o = '0;
    for (int l = 0; l < 4; l++)
      if (ref_lev[l] != 0 && ref_tab[l] < 128) o[ref_tab[l] % 16] = 1'b1;
    return o;
  endfunction

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 4; l++) begin ref_lev[l] = 0; ref_tab[l] = 128; end
    end else if (cfg_we) begin
      ref_tab[cfg_idx] = int'(cfg_wdata);
    end else if (evt_valid) begin
      ref_lev[ref_line(int'(evt_devfn), int'(evt_pin))] = int'(evt_level);
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // Cycle compare against the model
  always @(negedge clk) begin
    if (!done) begin
      chk("R6 ctrl_irq vs model", 32'(ctrl_irq), 32'(ref_out()));
      chk("R10 evt_ready vs model", 32'(evt_ready), 32'(!cfg_we));
      chk("R11 cfg_rdata vs model", 32'(cfg_rdata), 32'(ref_tab[cfg_ridx]));
    end
  end

  task automatic ev(logic [7:0] devfn, logic [1:0] pin, logic lvl);
    @(negedge clk); #1;
    evt_valid = 1'b1; evt_devfn = devfn; evt_pin = pin; evt_level = lvl;
    @(posedge clk); #1;
    evt_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] idx, logic [7:0] data);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL R5: watchdog expired, got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset ctrl_irq", 32'(ctrl_irq), 32'h0);
    chk("R9 reset entry", 32'(cfg_rdata), 32'h80);
    chk("R9 reset ready", 32'(evt_ready), 32'h1);

    for (int k = 0; k < 4; k++) wr(2'(k), 8'(k + 1));

    ev(8'hA0, 2'd3, 1'b1);
    chk("R2 slot20 pin3", 32'(ctrl_irq), 32'h0004);
    ev(8'hA5, 2'd3, 1'b0);
    chk("R1 function bits ignored", 32'(ctrl_irq), 32'h0000);
    ev(8'hA8, 2'd3, 1'b1);
    chk("R2 slot21 wrap", 32'(ctrl_irq), 32'h0008);
    ev(8'hA8, 2'd3, 1'b0);
    ev(8'h50, 2'd0, 1'b1);
    chk("R3 fixed slot10", 32'(ctrl_irq), 32'h0008);
    ev(8'h50, 2'd3, 1'b0);
    chk("R3 pin ignored on fixed slot", 32'(ctrl_irq), 32'h0000);
    ev(8'h5B, 2'd1, 1'b1);
    chk("R3 fixed slot11", 32'(ctrl_irq), 32'h0010);
    ev(8'h58, 2'd0, 1'b0);
    ev(8'h28, 2'd2, 1'b1);
    chk("R4 slot5 pass", 32'(ctrl_irq), 32'h0008);
    ev(8'h28, 2'd2, 1'b0);
    ev(8'hB0, 2'd1, 1'b1);
    chk("R4 slot22 pass", 32'(ctrl_irq), 32'h0004);
    ev(8'hB0, 2'd1, 1'b0);
    ev(8'h88, 2'd0, 1'b1);
    chk("R4 slot17 pass", 32'(ctrl_irq), 32'h0002);
    ev(8'h88, 2'd0, 1'b0);

    wr(2'd0, 8'h07);
    wr(2'd1, 8'h07);
    ev(8'h28, 2'd0, 1'b1);
    ev(8'h28, 2'd1, 1'b1);
    chk("R6 shared target", 32'(ctrl_irq), 32'h0080);
    ev(8'h28, 2'd0, 1'b0);
    chk("R6 OR keeps level", 32'(ctrl_irq), 32'h0080);
    ev(8'h28, 2'd1, 1'b0);
    chk("R6 OR clears", 32'(ctrl_irq), 32'h0000);

    ev(8'h28, 2'd2, 1'b1);
    chk("R5 level stored", 32'(ctrl_irq), 32'h0008);
    cfg_ridx = 2'd2;
    wr(2'd2, 8'h09);
    chk("R8 move leaves no stale level", 32'(ctrl_irq), 32'h0200);
    chk("R11 readback", 32'(cfg_rdata), 32'h09);
    wr(2'd2, 8'h89);
    chk("R7 disabled line silent", 32'(ctrl_irq), 32'h0000);
    wr(2'd2, 8'h0C);
    chk("R8 re-enable re-evaluates", 32'(ctrl_irq), 32'h1000);

    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_idx = 2'd3; cfg_wdata = 8'h0E;
    evt_valid = 1'b1; evt_devfn = 8'h28; evt_pin = 2'd3; evt_level = 1'b1;
    #1 chk("R10 ready low during write", 32'(evt_ready), 32'h0);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R10 event held back", 32'(ctrl_irq), 32'h1000);
    @(posedge clk); #1;
    evt_valid = 1'b0;
    @(negedge clk);
    chk("R10 stalled event accepted", 32'(ctrl_irq), 32'h5000);

    for (int n = 0; n < 3000; n++) begin
      bit stalled;
      @(negedge clk); #1;
      stalled = evt_valid && cfg_we;
      cfg_we   = ($urandom % 6) == 0;
      cfg_idx  = 2'($urandom);
      cfg_wdata = ($urandom % 4 == 0) ? 8'($urandom | 32'h80) : 8'($urandom % 16);
      cfg_ridx = 2'($urandom);
      if (!stalled) begin
        evt_valid = ($urandom % 3) != 0;
        evt_devfn = {5'($urandom % 32), 3'($urandom)};
        evt_pin   = 2'($urandom);
        evt_level = 1'($urandom);
      end
    end
    @(negedge clk); #1;
    cfg_we = 1'b0; evt_valid = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule